// File: doc/BRIEF.md
# Built-In-Test Health Aggregator

This block gathers every fault and self-test indication of an angular rate sensor and reduces them to the gross health outputs seen by the host. It produces four outputs:

- an active-high health flag;
- a fault bit and a commanded-test bit for the serial status byte;
- a control that forces the secondary analogue rate output to ground.

It also applies the fixed commanded-test offset to the digital rate word on its way out.

A commanded self-test can be requested in two ways: a discrete pin, or a bit from the serial control byte. The two requests are ORed. While the test runs, the health flag reads invalid and the rate word is raised by a fixed offset, 320 LSB (+10 deg/s at 1/32 deg/s per LSB). A self-test alone never grounds the secondary output; only a real fault does.

Real faults come from two places: a generic fault vector, and a range check on every auxiliary ADC sample. Each fault source is latched until reset. After reset the health flag is held invalid until a programmable number of millisecond ticks has been counted.

Top module: `bit_health_agg`

## Requirements
- R1: While the commanded test is active (stat_cbit high), health_ok is low and rate_out equals rate_in plus CBIT_OFFSET (default 320) one cycle later, clamped to the largest positive signed value of RATE_W bits.
- R2: The commanded test request is cbit_pin OR cbit_cmd; stat_cbit follows that OR one clock cycle later, for each of the four input combinations.
- R3: When aux_valid is high and the signed ADC_W-bit aux_code is below AUX_MIN or above AUX_MAX, stat_fault goes high two cycles later. Codes in the inclusive range, or any code presented while aux_valid is low, leave stat_fault low.
- R4: Any bit of fault_in set for one cycle raises stat_fault on the next cycle and drops health_ok on the cycle after, far inside a 25 ms budget.
- R5: After reset, health_ok stays low until STARTUP_TICKS ms_tick pulses have been counted. It rises two cycles after the cycle that carried the final tick, provided there is no fault and no test.
- R6: stat_fault and rate2_gnd stay high until reset once set. rate2_gnd follows stat_fault one cycle later. A commanded test alone never raises rate2_gnd.
- R7: During and directly after reset, every output (health_ok, stat_fault, stat_cbit, rate2_gnd, rate_out) is zero.
- R8: With no commanded test, rate_out equals rate_in one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cbit_pin | input | 1 | Discrete commanded-test request, high active |
| cbit_cmd | input | 1 | Commanded-test bit from the serial control byte |
| aux_valid | input | 1 | Auxiliary sample strobe |
| aux_code | input | ADC_W | Signed auxiliary ADC code |
| fault_in | input | FAULT_W | Internal fault indications, high active |
| rate_in | input | RATE_W | Signed digital rate word |
| rate_out | output | RATE_W | Rate word with the test offset applied when active |
| health_ok | output | 1 | High when the rate output is valid |
| stat_fault | output | 1 | Latched test-failure bit for the status byte |
| stat_cbit | output | 1 | Commanded test in progress |
| rate2_gnd | output | 1 | Force secondary analogue rate output to ground |

## Verification
The bound checker covers the following on every cycle:

- a request always shows as stat_cbit on the next cycle;
- an active test or a latched fault always pulls health_ok low;
- faults and the ground control never clear on their own;
- health_ok never rises before the checker's own tick count reaches the start-up threshold;
- the offset sum is exact wherever no clamp is needed.

Only the bench scenarios show the following:

- the exact range boundaries, through a sweep of every auxiliary code;
- that strobes with aux_valid low are ignored;
- the clamp at the top of the rate range;
- that health_ok recovers once a test ends.

// File: rtl/bit_health_pkg.sv
package bit_health_pkg;

  typedef enum logic [1:0] {
    HS_STARTUP = 2'd0,
    HS_RUN     = 2'd1,
    HS_TEST    = 2'd2,
    HS_FAULT   = 2'd3
  } health_state_e;

endpackage

// File: rtl/bit_aux_range.sv
module bit_aux_range #(
  parameter int ADC_W   = 12,
  parameter int AUX_MIN = -1800,
  parameter int AUX_MAX = 1800
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_valid,
  input  logic signed [ADC_W-1:0] sample_code,
  output logic                    range_err
);

  logic below, above;

  always_comb begin
    below = int'(sample_code) < AUX_MIN;
    above = int'(sample_code) > AUX_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) range_err <= 1'b0;
    else     range_err <= sample_valid && (below || above);
  end

endmodule

// File: rtl/bit_startup_timer.sv
module bit_startup_timer #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

endmodule

// File: rtl/bit_fault_latch.sv
module bit_fault_latch #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] sticky,
  output logic            any
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)         sticky[i] <= 1'b0;
      else if (src[i]) sticky[i] <= 1'b1;
    end
  end

  assign any = |sticky;

endmodule

// File: rtl/bit_health_agg.sv
module bit_health_agg
  import bit_health_pkg::*;
#(
  parameter int RATE_W        = 16,
  parameter int ADC_W         = 12,
  parameter int FAULT_W       = 4,
  parameter int STARTUP_TICKS = 500,
  parameter int CBIT_OFFSET   = 320,
  parameter int AUX_MIN       = -1800,
  parameter int AUX_MAX       = 1800
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ms_tick,
  input  logic                     cbit_pin,
  input  logic                     cbit_cmd,
  input  logic                     aux_valid,
  input  logic signed [ADC_W-1:0]  aux_code,
  input  logic [FAULT_W-1:0]       fault_in,
  input  logic signed [RATE_W-1:0] rate_in,
  output logic signed [RATE_W-1:0] rate_out,
  output logic                     health_ok,
  output logic                     stat_fault,
  output logic                     stat_cbit,
  output logic                     rate2_gnd
);

  localparam int NSRC = FAULT_W + 1;
  localparam logic signed [RATE_W:0]   OFF_EXT  = (RATE_W+1)'(CBIT_OFFSET);
  localparam logic signed [RATE_W:0]   SMAX_EXT = (RATE_W+1)'((2**(RATE_W-1)) - 1);
  localparam logic signed [RATE_W-1:0] SMAX     = RATE_W'((2**(RATE_W-1)) - 1);

  logic            aux_err;
  logic            startup_done;
  logic [NSRC-1:0] sticky;
  logic            fault_any;
  logic            cbit_q;
  health_state_e   state_q, state_nxt;
  logic signed [RATE_W:0] sum;

  bit_aux_range #(.ADC_W(ADC_W), .AUX_MIN(AUX_MIN), .AUX_MAX(AUX_MAX)) u_aux (
    .clk(clk), .rst(rst), .sample_valid(aux_valid), .sample_code(aux_code),
    .range_err(aux_err)
  );

  bit_startup_timer #(.LIMIT(STARTUP_TICKS)) u_start (
    .clk(clk), .rst(rst), .tick(ms_tick), .done(startup_done)
  );

  bit_fault_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst(rst), .src({aux_err, fault_in}), .sticky(sticky),
    .any(fault_any)
  );

  // health decision: fault outranks test, start-up outranks both
  always_comb begin
    if (!startup_done)  state_nxt = HS_STARTUP;
    else if (fault_any) state_nxt = HS_FAULT;
    else if (cbit_q)    state_nxt = HS_TEST;
    else                state_nxt = HS_RUN;
  end

  always_comb begin
    sum = {rate_in[RATE_W-1], rate_in} + (cbit_q ? OFF_EXT : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cbit_q    <= 1'b0;
      state_q   <= HS_STARTUP;
      rate2_gnd <= 1'b0;
      rate_out  <= '0;
    end else begin
      cbit_q    <= cbit_pin | cbit_cmd;
      state_q   <= state_nxt;
      rate2_gnd <= fault_any;
      rate_out  <= (sum > SMAX_EXT) ? SMAX : sum[RATE_W-1:0];
    end
  end

  assign health_ok  = (state_q == HS_RUN);
  assign stat_fault = fault_any;
  assign stat_cbit  = cbit_q;

endmodule

// File: rtl/bit_health_agg_chk.sv
module bit_health_agg_chk #(
  parameter int RATE_W        = 16,
  parameter int STARTUP_TICKS = 500,
  parameter int CBIT_OFFSET   = 320
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ms_tick,
  input logic                     cbit_pin,
  input logic                     cbit_cmd,
  input logic signed [RATE_W-1:0] rate_in,
  input logic signed [RATE_W-1:0] rate_out,
  input logic                     health_ok,
  input logic                     stat_fault,
  input logic                     stat_cbit,
  input logic                     rate2_gnd
);

  localparam int CW   = $clog2(STARTUP_TICKS + 1);
  localparam int RMAX = (2**(RATE_W-1)) - 1;

  logic [CW-1:0] ticks_seen;

  always_ff @(posedge clk) begin
    if (rst) ticks_seen <= '0;
    else if (ms_tick && (int'(ticks_seen) < STARTUP_TICKS)) ticks_seen <= ticks_seen + 1'b1;
  end

  AST_REQ_TO_CBIT: assert property (@(posedge clk) disable iff (rst)
    (cbit_pin || cbit_cmd) |=> stat_cbit); // R2
  AST_CBIT_BLOCKS_OK: assert property (@(posedge clk) disable iff (rst)
    stat_cbit |=> !health_ok); // R1
  AST_CBIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (stat_cbit && (int'(rate_in) <= RMAX - CBIT_OFFSET))
      |=> (int'(rate_out) == int'($past(rate_in)) + CBIT_OFFSET)); // R1
  AST_FAULT_BLOCKS_OK: assert property (@(posedge clk) disable iff (rst)
    stat_fault |=> !health_ok); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_fault |=> stat_fault); // R6
  AST_GND_FOLLOWS_FAULT: assert property (@(posedge clk) disable iff (rst)
    stat_fault |=> rate2_gnd); // R6
  AST_GND_STICKY: assert property (@(posedge clk) disable iff (rst)
    rate2_gnd |=> rate2_gnd); // R6
  AST_NO_EARLY_OK: assert property (@(posedge clk) disable iff (rst)
    (int'(ticks_seen) < STARTUP_TICKS) |-> !health_ok); // R5

endmodule

bind bit_health_agg bit_health_agg_chk #(
  .RATE_W(RATE_W), .STARTUP_TICKS(STARTUP_TICKS), .CBIT_OFFSET(CBIT_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .cbit_pin(cbit_pin),
  .cbit_cmd(cbit_cmd), .rate_in(rate_in), .rate_out(rate_out),
  .health_ok(health_ok), .stat_fault(stat_fault), .stat_cbit(stat_cbit),
  .rate2_gnd(rate2_gnd)
);

// File: tb/bit_health_agg_test.sv
module bit_health_agg_test;

  localparam int RATE_W  = 16;
  localparam int ADC_W   = 12;
  localparam int FAULT_W = 3;
  localparam int TICKS   = 6;
  localparam int OFFSET  = 320;
  localparam int AMIN    = -1800;
  localparam int AMAX    = 1800;
  localparam int RMAX    = 32767;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, cbit_pin = 1'b0, cbit_cmd = 1'b0, aux_valid = 1'b0;
  logic signed [ADC_W-1:0]  aux_code = '0;
  logic [FAULT_W-1:0]       fault_in = '0;
  logic signed [RATE_W-1:0] rate_in = '0;
  logic signed [RATE_W-1:0] rate_out;
  logic health_ok, stat_fault, stat_cbit, rate2_gnd;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  bit_health_agg #(
    .RATE_W(RATE_W), .ADC_W(ADC_W), .FAULT_W(FAULT_W), .STARTUP_TICKS(TICKS),
    .CBIT_OFFSET(OFFSET), .AUX_MIN(AMIN), .AUX_MAX(AMAX)
  ) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .cbit_pin(cbit_pin),
    .cbit_cmd(cbit_cmd), .aux_valid(aux_valid), .aux_code(aux_code),
    .fault_in(fault_in), .rate_in(rate_in), .rate_out(rate_out),
    .health_ok(health_ok), .stat_fault(stat_fault), .stat_cbit(stat_cbit),
    .rate2_gnd(rate2_gnd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic pulse_tick();
    ms_tick = 1'b1;
    step();
    ms_tick = 1'b0;
  endtask

  task automatic bring_up();
    do_reset();
    for (int i = 0; i < TICKS; i++) pulse_tick();
    step();
  endtask

  function automatic int exp_rate(input int r, input bit c);
    int s;
    s = r + (c ? OFFSET : 0);
    if (s > RMAX) s = RMAX;
    return s;
  endfunction

  int rvals[8] = '{0, 1, -1, 1234, -32768, 32447, 32448, 32767};

  initial begin
    // R7 reset state
    rst = 1'b1;
    step();
    step();
    chk("R7 health_ok", int'(health_ok), 0);
    chk("R7 stat_fault", int'(stat_fault), 0);
    chk("R7 stat_cbit", int'(stat_cbit), 0);
    chk("R7 rate2_gnd", int'(rate2_gnd), 0);
    chk("R7 rate_out", int'(rate_out), 0);
    rst = 1'b0;

    // R5 start-up hold
    for (int i = 0; i < TICKS - 1; i++) pulse_tick();
    step();
    step();
    chk("R5 hold before last tick", int'(health_ok), 0);
    pulse_tick();
    chk("R5 not yet one cycle after tick", int'(health_ok), 0);
    step();
    chk("R5 valid after last tick", int'(health_ok), 1);

    // R8 pass-through
    foreach (rvals[k]) begin
      rate_in = RATE_W'(rvals[k]);
      step();
      chk("R8 rate pass", int'(rate_out), exp_rate(rvals[k], 1'b0));
    end

    // R2 / R1 / R6 commanded test, all request combinations
    for (int p = 0; p < 4; p++) begin
      bring_up();
      cbit_pin = p[0];
      cbit_cmd = p[1];
      step();
      chk("R2 stat_cbit", int'(stat_cbit), int'(p != 0));
      step();
      chk("R1 health during test", int'(health_ok), int'(p == 0));
      chk("R6 no ground from test", int'(rate2_gnd), 0);
      chk("R6 no fault from test", int'(stat_fault), 0);
      foreach (rvals[k]) begin
        rate_in = RATE_W'(rvals[k]);
        step();
        chk("R1 rate offset", int'(rate_out), exp_rate(rvals[k], p != 0));
      end
      cbit_pin = 1'b0;
      cbit_cmd = 1'b0;
      step();
      chk("R2 stat_cbit released", int'(stat_cbit), 0);
      step();
      chk("R1 health after test", int'(health_ok), 1);
    end

    // R4 / R6 fault vector
    for (int b = 0; b < FAULT_W; b++) begin
      bring_up();
      fault_in = FAULT_W'(1 << b);
      step();
      fault_in = '0;
      chk("R4 stat_fault", int'(stat_fault), 1);
      step();
      chk("R4 health drop", int'(health_ok), 0);
      chk("R6 ground", int'(rate2_gnd), 1);
      step();
      step();
      step();
      chk("R6 fault latched", int'(stat_fault), 1);
      chk("R6 ground latched", int'(rate2_gnd), 1);
      chk("R4 health stays low", int'(health_ok), 0);
    end

    // R3 exhaustive auxiliary code sweep
    for (int c = -2048; c < 2048; c++) begin
      do_reset();
      aux_valid = 1'b1;
      aux_code  = ADC_W'(c);
      step();
      aux_valid = 1'b0;
      chk("R3 no fault after one cycle", int'(stat_fault), 0);
      step();
      chk("R3 aux range", int'(stat_fault), int'((c < AMIN) || (c > AMAX)));
    end

    // R3 out-of-range codes without strobe are ignored
    do_reset();
    aux_valid = 1'b0;
    aux_code  = ADC_W'(-2048);
    step();
    aux_code  = ADC_W'(2047);
    step();
    step();
    step();
    chk("R3 ignored without strobe", int'(stat_fault), 0);
    chk("R3 no ground without strobe", int'(rate2_gnd), 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule